// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Controller

This block watches the level signals of one receive channel: signal detect on two inputs (IN0, IN1), clock-recovery lock, and an eye-opening threshold flag. It turns their transitions into sticky event bits in one status byte. Each detect input and the lock signal raise two separate events, one when they assert and one when they drop. The eye flag raises an event only when it asserts. The status byte also holds one live bit: the current signal-detect level of the input chosen by `inputSel`.

Software reads the status byte through a read strobe and an address. That read returns the byte and clears every sticky bit in the same cycle. An event that arrives in that same cycle is kept for the next read. An enable byte gates the sticky bits onto the active-high `irqOut`. A select bit decides whether the loss-of-signal pin carries that interrupt or the live detect level. Two further read-only bytes report the live per-input loss-of-signal state and the lock state.

Top module: `evt_irq_ctl`

## Requirements
- R1: A rising level on lock, IN1 detect or IN0 detect sets status bit 6, 5 or 4 in that order, and the bit stays set until the status byte is read.
- R2: A falling level on lock, IN1 detect or IN0 detect sets status bit 2, 1 or 0 in that order, and the bit stays set until the status byte is read.
- R3: A rising eye-threshold flag sets status bit 3. Its falling edge sets nothing.
- R4: Status bit 7 is the synchronized detect level of IN1 when `inputSel`=1 and of IN0 when `inputSel`=0. It follows that level and is never latched.
- R5: Address 0x54 selects the status byte on `rdData`. With `rdStrobe`=1, `rdData` shows the value before the clear, and bits 6:0 clear at that clock edge. A strobe at any other address clears nothing.
- R6: An event that is detected at the same edge as the clear stays set after the clear.
- R7: `irqOut` is 1 exactly when some status bit in 6:0 and the enable bit at the same position are both 1. Enable bit 7 has no effect. Sticky bits latch whether or not they are enabled.
- R8: `losPin` equals `irqOut` when `losIntSel`=1. When `losIntSel`=0 it equals the selected detect level (status bit 7).
- R9: Address 0x01 returns the live loss-of-signal byte: bit 1 = NOT IN1 detect, bit 0 = NOT IN0 detect, all other bits 0.
- R10: Address 0x02 returns the lock byte: bits 4:3 are 2'b11 when locked and 2'b00 when not, all other bits 0. Any unmapped address returns 0x00.
- R11: After reset, every sticky bit is 0 and `irqOut` is 0.
- R12: Each level input passes through a two-stage synchronizer. A change applied before clock edge k shows in the status byte after edge k+2 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sigDetIn | input | 2 | Raw signal detect, bit 1 = IN1, bit 0 = IN0, 1 = signal present |
| cdrLockIn | input | 1 | Raw clock-recovery lock level |
| eyeThreshIn | input | 1 | Raw eye-opening threshold flag |
| inputSel | input | 1 | Chooses which input's detect level is reported live |
| losIntSel | input | 1 | 1: loss pin carries interrupt, 0: carries detect level |
| rdStrobe | input | 1 | Register read strobe |
| rdAddr | input | 8 | Register read address |
| intEnable | input | 8 | Interrupt enable byte, bits 6:0 match the status layout |
| rdData | output | 8 | Read data for the addressed byte |
| irqOut | output | 1 | Active-high interrupt |
| losPin | output | 1 | Loss-of-signal pin output |

## Verification
The main function is driven with a sequence of level patterns: single rises, simultaneous rises on two sources, single falls, and a rise together with a fall. Each pattern is paired with an enable byte chosen so that masked, unmasked and reserved-only enables can be told apart on `irqOut`. Alternating clear and no-clear steps show whether bits are sticky, and show that the live bit 7 follows the input rather than latching. Switching `inputSel` and `losIntSel` between steps shows which source the pin and bit 7 take. A directed test places a detect edge exactly on the clear edge. It separates a design that keeps the new event from one that drops it, and it also checks the two-edge synchronizer latency.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  localparam int NUM_DET   = 2;
  localparam int LVL_W     = NUM_DET + 2;
  localparam int LOCK_IDX  = NUM_DET;
  localparam int EYE_IDX   = NUM_DET + 1;
  localparam int STICKY_W  = 7;
  localparam int GAIN_BASE = 4;
  localparam int EYE_BIT   = 3;
  localparam int LOCK_LOSS = 2;
  localparam int LOCK_GAIN = 6;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_INT  = 2'd1,
    RD_LOS  = 2'd2,
    RD_CDR  = 2'd3
  } rdSel_e;

  typedef struct packed {
    logic   clearSticky;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/evt_irq_sync.sv
module evt_irq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[0] <= '0;
        else       pipe[0] <= rawIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= pipe[s-1];
      end
    end
  end

  assign syncOut = pipe[STAGES-1];

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] INT_ADDR = 8'h54,
  parameter logic [ADDR_W-1:0] LOS_ADDR = 8'h01,
  parameter logic [ADDR_W-1:0] CDR_ADDR = 8'h02
) (
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  output ctrlStrobe_t       strobe
);

  always_comb begin
    strobe.rdSel = RD_NONE;
    if (rdAddr == INT_ADDR)      strobe.rdSel = RD_INT;
    else if (rdAddr == LOS_ADDR) strobe.rdSel = RD_LOS;
    else if (rdAddr == CDR_ADDR) strobe.rdSel = RD_CDR;
    strobe.clearSticky = rdStrobe && (rdAddr == INT_ADDR);
  end

endmodule

// File: rtl/evt_irq_datapath.sv
module evt_irq_datapath
  import evt_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [LVL_W-1:0]    syncLvl,
  input  logic                inputSel,
  input  logic                losIntSel,
  input  logic [7:0]          intEnable,
  input  ctrlStrobe_t         strobe,
  output logic [7:0]          rdData,
  output logic                irqOut,
  output logic                losPin,
  output logic [STICKY_W-1:0] evtVec,
  output logic [STICKY_W-1:0] stickyBits
);

  logic [LVL_W-1:0]    prevLvl;
  logic [LVL_W-1:0]    riseLvl;
  logic [LVL_W-1:0]    fallLvl;
  logic                selLevel;
  logic [7:0]          statusByte;
  logic [7:0]          losByte;
  logic [7:0]          cdrByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLvl <= '0;
    else       prevLvl <= syncLvl;
  end

  assign riseLvl = syncLvl & ~prevLvl;
  assign fallLvl = ~syncLvl & prevLvl;

  always_comb begin
    evtVec = '0;
    for (int i = 0; i < NUM_DET; i++) begin
      evtVec[GAIN_BASE + i] = riseLvl[i];
      evtVec[i]             = fallLvl[i];
    end
    evtVec[LOCK_GAIN] = riseLvl[LOCK_IDX];
    evtVec[LOCK_LOSS] = fallLvl[LOCK_IDX];
    evtVec[EYE_BIT]   = riseLvl[EYE_IDX];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   stickyBits <= '0;
    else if (strobe.clearSticky) stickyBits <= evtVec;
    else                         stickyBits <= stickyBits | evtVec;
  end

  assign selLevel   = inputSel ? syncLvl[1] : syncLvl[0];
  assign statusByte = {selLevel, stickyBits};

  always_comb begin
    losByte = '0;
    for (int i = 0; i < NUM_DET; i++) losByte[i] = ~syncLvl[i];
    cdrByte = '0;
    cdrByte[4:3] = {2{syncLvl[LOCK_IDX]}};
  end

  always_comb begin
    case (strobe.rdSel)
      RD_INT:  rdData = statusByte;
      RD_LOS:  rdData = losByte;
      RD_CDR:  rdData = cdrByte;
      default: rdData = 8'h00;
    endcase
  end

  assign irqOut = |(stickyBits & intEnable[STICKY_W-1:0]);
  assign losPin = losIntSel ? irqOut : selLevel;

endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
  import evt_irq_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] INT_ADDR    = 8'h54,
  parameter logic [ADDR_W-1:0] LOS_ADDR    = 8'h01,
  parameter logic [ADDR_W-1:0] CDR_ADDR    = 8'h02,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        sigDetIn,
  input  logic              cdrLockIn,
  input  logic              eyeThreshIn,
  input  logic              inputSel,
  input  logic              losIntSel,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [7:0]        intEnable,
  output logic [7:0]        rdData,
  output logic              irqOut,
  output logic              losPin
);

  logic [LVL_W-1:0]    syncLvl;
  ctrlStrobe_t         strobe;
  logic [STICKY_W-1:0] evtVec;
  logic [STICKY_W-1:0] stickyBits;

  evt_irq_sync #(.WIDTH(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({eyeThreshIn, cdrLockIn, sigDetIn}),
    .syncOut (syncLvl)
  );

  evt_irq_ctrl #(
    .ADDR_W(ADDR_W), .INT_ADDR(INT_ADDR), .LOS_ADDR(LOS_ADDR), .CDR_ADDR(CDR_ADDR)
  ) u_ctrl (
    .rdStrobe (rdStrobe),
    .rdAddr   (rdAddr),
    .strobe   (strobe)
  );

  evt_irq_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .syncLvl    (syncLvl),
    .inputSel   (inputSel),
    .losIntSel  (losIntSel),
    .intEnable  (intEnable),
    .strobe     (strobe),
    .rdData     (rdData),
    .irqOut     (irqOut),
    .losPin     (losPin),
    .evtVec     (evtVec),
    .stickyBits (stickyBits)
  );

endmodule

// File: rtl/evt_irq_ctl_chk.sv
module evt_irq_ctl_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] INT_ADDR = 8'h54
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStrobe,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [7:0]        intEnable,
  input logic              irqOut,
  input logic              losIntSel,
  input logic              losPin,
  input logic [6:0]        evtVec,
  input logic [6:0]        stickyBits
);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_GAIN_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec[6:3]) |=> ((stickyBits[6:3] & $past(evtVec[6:3])) == $past(evtVec[6:3]))); // R1

  AST_LOSS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (|evtVec[2:0]) |=> ((stickyBits[2:0] & $past(evtVec[2:0])) == $past(evtVec[2:0]))); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> ((stickyBits & ~$past(stickyBits) & ~$past(evtVec)) == 7'd0)); // R3

  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == INT_ADDR) |=> (stickyBits == $past(evtVec))); // R6

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && rdAddr == INT_ADDR && evtVec == 7'd0) |=> !irqOut); // R5

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((stickyBits & intEnable[6:0]) == 7'd0) |-> !irqOut); // R7

  AST_PIN_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    losIntSel |-> (losPin == irqOut)); // R8

endmodule

bind evt_irq_ctl evt_irq_ctl_chk #(.ADDR_W(ADDR_W), .INT_ADDR(INT_ADDR)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rdStrobe   (rdStrobe),
  .rdAddr     (rdAddr),
  .intEnable  (intEnable),
  .irqOut     (irqOut),
  .losIntSel  (losIntSel),
  .losPin     (losPin),
  .evtVec     (evtVec),
  .stickyBits (stickyBits)
);

// File: tb/evt_irq_ctl_bench.sv
module evt_irq_ctl_bench;

  localparam logic [7:0] A_INT = 8'h54;
  localparam logic [7:0] A_LOS = 8'h01;
  localparam logic [7:0] A_CDR = 8'h02;

  typedef struct packed {
    logic [1:0] sd;
    logic       lock;
    logic       eye;
    logic       isel;
    logic       lsel;
    logic [7:0] en;
    logic       clr;
    logic [7:0] expStat;
    logic       expIrq;
    logic       expPin;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h90, 1'b0, 1'b1},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h10, 1'b0, 8'h80, 1'b0, 1'b1},
    '{2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 8'h70, 1'b0, 8'hE0, 1'b1, 1'b1},
    '{2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 8'h70, 1'b1, 8'h61, 1'b1, 1'b0},
    '{2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0},
    '{2'b10, 1'b0, 1'b1, 1'b1, 1'b1, 8'h08, 1'b1, 8'h8C, 1'b1, 1'b1},
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h80, 1'b1, 8'h02, 1'b0, 1'b0},
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h7F, 1'b0, 8'h00, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] sigDetIn = 2'b00;
  logic       cdrLockIn = 1'b0;
  logic       eyeThreshIn = 1'b0;
  logic       inputSel = 1'b0;
  logic       losIntSel = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rdAddr = 8'h00;
  logic [7:0] intEnable = 8'h00;
  logic [7:0] rdData;
  logic       irqOut;
  logic       losPin;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  evt_irq_ctl u_evt_irq_ctl (
    .clk(clk), .rstN(rstN), .sigDetIn(sigDetIn), .cdrLockIn(cdrLockIn),
    .eyeThreshIn(eyeThreshIn), .inputSel(inputSel), .losIntSel(losIntSel),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .intEnable(intEnable),
    .rdData(rdData), .irqOut(irqOut), .losPin(losPin)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic clearRead();
    rdAddr   = A_INT;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    peek(A_INT, d);
    check("R11 status after reset", d, 8'h00);
    check("R11 irq after reset", {7'd0, irqOut}, 8'h00);

    // Vector table: R1 R2 R3 R4 R5 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      sigDetIn    = VECS[v].sd;
      cdrLockIn   = VECS[v].lock;
      eyeThreshIn = VECS[v].eye;
      inputSel    = VECS[v].isel;
      losIntSel   = VECS[v].lsel;
      intEnable   = VECS[v].en;
      repeat (4) @(negedge clk);
      peek(A_INT, d);
      check($sformatf("R1 R2 R3 R4 R5 status vec %0d", v), d, VECS[v].expStat);
      check($sformatf("R7 irq vec %0d", v), {7'd0, irqOut}, {7'd0, VECS[v].expIrq});
      check($sformatf("R8 pin vec %0d", v), {7'd0, losPin}, {7'd0, VECS[v].expPin});
      if (VECS[v].clr) clearRead();
    end

    // R9 / R10: live bytes and unmapped address
    peek(A_LOS, d);
    check("R9 los byte no signal", d, 8'h03);
    peek(A_CDR, d);
    check("R10 cdr byte unlocked", d, 8'h00);
    peek(8'h33, d);
    check("R10 unmapped address", d, 8'h00);

    // Lock gained -> bit 6 pending
    cdrLockIn = 1'b1;
    repeat (4) @(negedge clk);
    peek(A_CDR, d);
    check("R10 cdr byte locked", d, 8'h18);

    // R12 + R6: IN0 rises; the clear lands on the edge the event latches
    sigDetIn = 2'b01;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    peek(A_INT, d);
    check("R12 not yet visible after two edges", d, 8'h40);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    peek(A_INT, d);
    check("R6 coincident event kept, old cleared", d, 8'h10);
    peek(A_LOS, d);
    check("R9 los byte IN0 present", d, 8'h02);

    // R5: strobe at another address does not clear
    rdAddr = A_LOS;
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    peek(A_INT, d);
    check("R5 non-status read keeps bits", d, 8'h10);

    // R7: enable now set, irq up; clear drops it; R4 bit7 with inputSel=0
    intEnable = 8'h10;
    inputSel  = 1'b0;
    #1;
    check("R7 irq with enabled pending bit", {7'd0, irqOut}, 8'h01);
    peek(A_INT, d);
    rdStrobe = 1'b1;
    #1;
    check("R5 read shows pre-clear value", rdData, 8'h90);
    @(negedge clk);
    rdStrobe = 1'b0;
    peek(A_INT, d);
    check("R4 R5 after clear only live bit", d, 8'h80);
    check("R7 irq after clear", {7'd0, irqOut}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule